// File: doc/BRIEF.md
# Paged Window Address Translator

This block sits beside the fixed memory decoder of a small embedded CPU subsystem. It takes a 24-bit CPU memory address and the space that the fixed decoder chose for it. When the address falls in one of two paging windows, it may replace both the space and the address. Window A is eight consecutive 16 KB pages whose start can be moved. Window B is four 16 KB pages starting at 0xA0000. Each page can be sent to any 16 KB boundary in DRAM, the boot ROM, the DOS chip-select space or one of four removable-card memory spaces. The card spaces are 26 bits wide and can only be reached through these windows. While system-management mode is active, the block also sends the 16 KB region at 0x60000 to a chosen DRAM page.

The translation path is purely combinational: its outputs follow the CPU address, the fixed decode and the mode inputs within the same cycle. Software sets up the page registers through a two-step index/data port. That port is run by a two-state machine. In `CFG_IDLE`, an index write moves the machine to `CFG_ARMED`. In `CFG_ARMED`, another index write replaces the held index and the machine stays armed; a data write stores the data into the indexed register and returns the machine to `CFG_IDLE`. A data write in `CFG_IDLE` is dropped.

Top module: `pgwin_xlate`

## Requirements
- R1: After reset every page register, the control register and the management-mode page register are zero. With `smm_active` low, `xl_hit` is then 0 and the block passes every access through.
- R2: A write with `cfg_sel`=0 loads an index from `cfg_wdata[4:0]` and arms the port. The next write with `cfg_sel`=1 stores `cfg_wdata` into the indexed register and disarms the port. Further index writes while armed replace the held index. A data write while not armed is ignored. Index values are: 0–7 for window A pages, 8–11 for window B pages, 12 for control and 13 for the management-mode page. Any other index stores nothing.
- R3: A page register holds the enable in bit 15, the target-space code in bits 14:12 and the 16 KB target page number in bits 11:0. The control register holds the window A global enable in bit 0, the window B global enable in bit 1 and the window A start step k in bits 4:2. The management-mode register holds a DRAM page number in bits 9:0.
- R4: Window B page n (n = 0..3) covers 0xA0000 + n·0x4000 up to that address + 0x3FFF.
- R5: Window A page n (n = 0..7) covers 0xC0000 + (k+n)·0x4000 up to that address + 0x3FFF. A written k above 5 is stored as 5, so the highest start is 0xD4000.
- R6: A window page translates only when all of these hold: its window's global enable is set, its own enable is set, `nt_space` is local/ISA (code 3), and its target code is not 3.
- R7: A translated address is the page number concatenated with `cpu_addr[13:0]`. For card spaces (codes 4–7), all 12 page bits are used. For the 16 MB spaces (codes 0–2), only page bits 9:0 are used and `xl_addr[25:24]` is 0.
- R8: An access that is not translated gives `xl_hit`=0, `xl_space`=`nt_space` and `xl_addr` = `cpu_addr` zero-extended.
- R9: With `smm_active` high, every address in 0x60000–0x63FFF gives `xl_hit`=1 and space DRAM (code 0), at the stored management-mode page with the low 14 address bits kept. This applies whatever `nt_space` is. With `smm_active` low, that region follows the other rules.
- R10: Space codes are: 0 DRAM, 1 boot ROM, 2 DOS chip select, 3 local/ISA bus, 4 card 0 data, 5 card 0 attribute, 6 card 1 data, 7 card 1 attribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration port |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = index write, 1 = data write |
| cfg_wdata | input | 16 | Index or register data |
| cpu_addr | input | 24 | CPU memory address |
| nt_space | input | 3 | Space chosen by the fixed decoder |
| smm_active | input | 1 | System-management mode active |
| xl_addr | output | 26 | Address in the target space |
| xl_space | output | 3 | Target space code |
| xl_hit | output | 1 | Access was translated by this block |

## Verification
Each configuration is checked by sweeping every 16 KB page from 0x50000 to 0x10FFFF. Each page is tried at two offsets, with all four fixed-decode codes and with the mode input both low and high. The DRAM, boot-ROM and DOS codes separate the "fixed decode owns the address" case from the local/ISA case. The mode input separates the management remap from ordinary pass-through at 0x60000. The configurations cover all target codes, including a local/ISA target and pages that are switched off. They also cover a page number with its top bits set, which shows the 16 MB truncation against the full 26-bit card address. Other configurations move the start of window A, including a start step written above its limit, and switch off each window's global enable. Stray data writes, indexes outside the map and replaced indexes are each followed by a full sweep, which shows that the mapping did not change.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
    typedef enum logic [2:0] {
        SP_DRAM    = 3'd0,
        SP_BROM    = 3'd1,
        SP_DOSCS   = 3'd2,
        SP_LOCAL   = 3'd3,
        SP_C0_DAT  = 3'd4,
        SP_C0_ATT  = 3'd5,
        SP_C1_DAT  = 3'd6,
        SP_C1_ATT  = 3'd7
    } space_t;

    localparam int TPN_W = 12;   // target page number width (26-bit spaces)
    localparam int REG_W = 16;

    typedef struct packed {
        logic             en;
        space_t           sp;
        logic [TPN_W-1:0] pnum;
    } pgreg_t;

    typedef enum logic {
        CFG_IDLE  = 1'b0,
        CFG_ARMED = 1'b1
    } cfg_st_t;
endpackage

// File: rtl/pgwin_cfg.sv
module pgwin_cfg
    import pgwin_pkg::*;
#(
    parameter int NPG       = 12,
    parameter int IDX_W     = 5,
    parameter int SMM_W     = 10,
    parameter int K_MAX     = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_sel,
    input  logic [REG_W-1:0]      cfg_wdata,
    output pgreg_t [NPG-1:0]      pg_q,
    output logic                  a_en,
    output logic                  b_en,
    output logic [2:0]            a_k,
    output logic [SMM_W-1:0]      smm_pg
);
    localparam int IDX_CTL = NPG;
    localparam int IDX_SMM = NPG + 1;

    cfg_st_t          st_q, st_nx;
    logic [IDX_W-1:0] idx_q;
    logic             commit;
    logic [2:0]       k_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CFG_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            CFG_IDLE:  if (cfg_we && !cfg_sel) st_nx = CFG_ARMED;
            CFG_ARMED: if (cfg_we &&  cfg_sel) st_nx = CFG_IDLE;
            default:   st_nx = CFG_IDLE;
        endcase
    end

    always_comb begin
        commit = (st_q == CFG_ARMED) && cfg_we && cfg_sel;
        k_wr   = (cfg_wdata[4:2] > 3'(K_MAX)) ? 3'(K_MAX) : cfg_wdata[4:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  idx_q <= '0;
        else if (cfg_we && !cfg_sel) idx_q <= cfg_wdata[IDX_W-1:0];
    end

    for (genvar i = 0; i < NPG; i++) begin : g_pg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pg_q[i] <= '0;
            else if (commit && idx_q == IDX_W'(i))
                pg_q[i] <= pgreg_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_en   <= 1'b0;
            b_en   <= 1'b0;
            a_k    <= '0;
            smm_pg <= '0;
        end else if (commit) begin
            if (idx_q == IDX_W'(IDX_CTL)) begin
                a_en <= cfg_wdata[0];
                b_en <= cfg_wdata[1];
                a_k  <= k_wr;
            end
            if (idx_q == IDX_W'(IDX_SMM))
                smm_pg <= cfg_wdata[SMM_W-1:0];
        end
    end
endmodule

// File: rtl/pgwin_lookup.sv
module pgwin_lookup #(
    parameter int PN_W   = 10,
    parameter int NA     = 8,
    parameter int NB     = 4,
    parameter int A_BASE = 'h30,
    parameter int B_BASE = 'h28
) (
    input  logic [PN_W-1:0]   pn,
    input  logic              a_en,
    input  logic              b_en,
    input  logic [2:0]        a_k,
    output logic [NA+NB-1:0]  sel_oh
);
    for (genvar i = 0; i < NA; i++) begin : g_a
        assign sel_oh[i] = a_en &&
            (pn == PN_W'(A_BASE + i) + PN_W'(a_k));
    end
    for (genvar j = 0; j < NB; j++) begin : g_b
        assign sel_oh[NA+j] = b_en && (pn == PN_W'(B_BASE + j));
    end
endmodule

// File: rtl/pgwin_xlate.sv
module pgwin_xlate
    import pgwin_pkg::*;
#(
    parameter int CPU_AW  = 24,
    parameter int TGT_AW  = 26,
    parameter int PG_SH   = 14,
    parameter int NA      = 8,
    parameter int NB      = 4,
    parameter int SMM_PN  = 'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [15:0]       cfg_wdata,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [2:0]        nt_space,
    input  logic              smm_active,
    output logic [TGT_AW-1:0] xl_addr,
    output logic [2:0]        xl_space,
    output logic              xl_hit
);
    localparam int NPG   = NA + NB;
    localparam int PN_W  = CPU_AW - PG_SH;
    localparam int WIDE  = TGT_AW - PG_SH;

    pgreg_t [NPG-1:0]  pg_q;
    logic              a_en, b_en;
    logic [2:0]        a_k;
    logic [PN_W-1:0]   smm_pg;
    logic [NPG-1:0]    sel_oh;
    logic [PN_W-1:0]   pn;
    pgreg_t            sel_reg;
    logic              pg_ok, smm_hit;

    assign pn = cpu_addr[CPU_AW-1:PG_SH];

    pgwin_cfg #(.NPG(NPG), .IDX_W(5), .SMM_W(PN_W), .K_MAX(5)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .pg_q(pg_q), .a_en(a_en), .b_en(b_en),
        .a_k(a_k), .smm_pg(smm_pg)
    );

    pgwin_lookup #(.PN_W(PN_W), .NA(NA), .NB(NB)) u_lk (
        .pn(pn), .a_en(a_en), .b_en(b_en), .a_k(a_k), .sel_oh(sel_oh)
    );

    always_comb begin
        sel_reg = '0;
        for (int i = 0; i < NPG; i++)
            if (sel_oh[i]) sel_reg = sel_reg | pg_q[i];
        pg_ok   = (|sel_oh) && sel_reg.en && (nt_space == SP_LOCAL)
                  && (sel_reg.sp != SP_LOCAL);
        smm_hit = smm_active && (pn == PN_W'(SMM_PN));
    end

    always_comb begin
        xl_hit   = 1'b0;
        xl_space = nt_space;
        xl_addr  = TGT_AW'(cpu_addr);
        if (smm_hit) begin
            xl_hit   = 1'b1;
            xl_space = SP_DRAM;
            xl_addr  = TGT_AW'({smm_pg, cpu_addr[PG_SH-1:0]});
        end else if (pg_ok) begin
            xl_hit   = 1'b1;
            xl_space = sel_reg.sp;
            if (sel_reg.sp[2])
                xl_addr = {sel_reg.pnum[WIDE-1:0], cpu_addr[PG_SH-1:0]};
            else
                xl_addr = TGT_AW'({sel_reg.pnum[PN_W-1:0], cpu_addr[PG_SH-1:0]});
        end
    end
endmodule

// File: rtl/pgwin_chk.sv
module pgwin_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] cpu_addr,
    input logic [2:0]  nt_space,
    input logic        smm_active,
    input logic [25:0] xl_addr,
    input logic [2:0]  xl_space,
    input logic        xl_hit
);
    logic in_smm;
    assign in_smm = smm_active && (cpu_addr[23:14] == 10'h18);

    assert_hit_not_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> xl_space != 3'd3);
    assert_hit_needs_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_hit && !in_smm) |-> nt_space == 3'd3);
    assert_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_hit |-> (xl_space == nt_space && xl_addr == {2'b00, cpu_addr}));
    assert_offset_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> xl_addr[13:0] == cpu_addr[13:0]);
    assert_narrow_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_hit && !xl_space[2]) |-> xl_addr[25:24] == 2'b00);
    assert_smm_remap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_smm |-> (xl_hit && xl_space == 3'd0));
endmodule

bind pgwin_xlate pgwin_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .nt_space(nt_space),
    .smm_active(smm_active), .xl_addr(xl_addr), .xl_space(xl_space),
    .xl_hit(xl_hit)
);

// File: tb/tb_pgwin_xlate.sv
module tb_pgwin_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [23:0] cpu_addr = '0;
    logic [2:0]  nt_space = 3'd3;
    logic        smm_active = 1'b0;
    logic [25:0] xl_addr;
    logic [2:0]  xl_space;
    logic        xl_hit;

    int total = 0, bad = 0;
    bit done = 0;

    logic [15:0] m_pg [12];
    logic        m_aen = 0, m_ben = 0;
    int          m_k = 0;
    logic [9:0]  m_smm = '0;

    always #2 clk = ~clk;

    pgwin_xlate dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr), .nt_space(nt_space),
        .smm_active(smm_active), .xl_addr(xl_addr), .xl_space(xl_space),
        .xl_hit(xl_hit)
    );

    task automatic bus_wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R2: index then data; the model follows R3/R5 layout
    task automatic reg_wr(input int idx, input logic [15:0] d);
        bus_wr(1'b0, 16'(idx));
        bus_wr(1'b1, d);
        if (idx < 12) m_pg[idx] = d;
        else if (idx == 12) begin
            m_aen = d[0]; m_ben = d[1];
            m_k = (d[4:2] > 3'd5) ? 5 : int'(d[4:2]);
        end else if (idx == 13) m_smm = d[9:0];
    endtask

    function automatic logic [15:0] pgv(input bit en, input int sp, input int pn);
        return {en, 3'(sp), 12'(pn)};
    endfunction

    task automatic check_one(input string phase, input logic [23:0] a,
                             input logic [2:0] nt, input logic smm);
        logic [25:0] ea; logic [2:0] es; logic eh;
        int pn, idx; string req;
        logic [15:0] r;
        ea = {2'b00, a}; es = nt; eh = 1'b0; idx = -1;
        pn = int'(a[23:14]);
        req = "R8";
        if (smm && pn == 'h18) begin
            eh = 1; es = 3'd0; ea = {2'b00, m_smm, a[13:0]}; req = "R9";
        end else begin
            if (m_ben && pn >= 'h28 && pn < 'h2C) begin idx = 8 + pn - 'h28; req = "R4"; end
            if (m_aen && pn >= 'h30 + m_k && pn < 'h38 + m_k) begin idx = pn - 'h30 - m_k; req = "R5"; end
            if (idx >= 0) begin
                r = m_pg[idx];
                if (r[15] && nt == 3'd3 && r[14:12] != 3'd3) begin
                    eh = 1; es = r[14:12];
                    ea = es[2] ? {r[11:0], a[13:0]} : {2'b00, r[9:0], a[13:0]};
                    req = "R7";
                end else req = "R6";
            end
        end
        if (phase != "") req = phase;
        @(negedge clk);
        cpu_addr = a; nt_space = nt; smm_active = smm;
        #1;
        total++;
        if (xl_hit !== eh || xl_space !== es || xl_addr !== ea) begin
            bad++;
            $display("FAIL %s addr=%h nt=%0d smm=%0b: got hit=%0b sp=%0d a=%h exp hit=%0b sp=%0d a=%h",
                     req, a, nt, smm, xl_hit, xl_space, xl_addr, eh, es, ea);
        end
    endtask

    task automatic sweep(input string phase);
        for (int p = 'h14; p < 'h44; p++)
            for (int nt = 0; nt < 4; nt++)
                for (int s = 0; s < 2; s++) begin
                    check_one(phase, 24'(p << 14), 3'(nt), 1'(s));
                    check_one(phase, 24'((p << 14) | ((p * 613) & 'h3FFF)), 3'(nt), 1'(s));
                end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        bad++; total++;
        $display("FAIL watchdog: got running exp finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 12; i++) m_pg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, all pass-through (SMM still remaps, modelled as R9)
        for (int p = 'h14; p < 'h44; p++)
            for (int nt = 0; nt < 4; nt++)
                check_one("R1", 24'(p << 14), 3'(nt), 1'b0);
        sweep("");

        // configuration 1: both windows, k=2, R10 codes all used
        reg_wr(0,  pgv(1, 0, 'hC05));   // DRAM, top page bits dropped (R7)
        reg_wr(1,  pgv(1, 4, 'hFFF));
        reg_wr(2,  pgv(1, 3, 'h010));   // local target never hits (R6)
        reg_wr(3,  pgv(0, 1, 'h020));   // disabled
        reg_wr(4,  pgv(1, 2, 'h3FF));
        reg_wr(5,  pgv(1, 7, 'h801));
        reg_wr(6,  pgv(1, 5, 'h123));
        reg_wr(7,  pgv(1, 6, 'h456));
        reg_wr(8,  pgv(1, 1, 'h0FF));
        reg_wr(9,  pgv(1, 0, 'h02B));
        reg_wr(10, pgv(0, 0, 'h001));
        reg_wr(11, pgv(1, 4, 'hABC));
        reg_wr(13, 16'h012B);
        reg_wr(12, 16'h000B);
        sweep("");

        // R2: stray data writes, unmapped index, replaced index
        bus_wr(1'b1, 16'h000F);
        bus_wr(1'b1, 16'h0000);
        sweep("R2");
        bus_wr(1'b0, 16'd14);
        bus_wr(1'b1, 16'hFFFF);
        sweep("R2");
        bus_wr(1'b0, 16'd0);
        bus_wr(1'b0, 16'd9);
        bus_wr(1'b1, pgv(1, 6, 'h777));
        m_pg[9] = pgv(1, 6, 'h777);
        sweep("R2");

        // configuration 2: k written as 7 clamps to 5 (R5), B off
        reg_wr(12, 16'h001D);
        sweep("");
        // configuration 3: A off, B on, k=0
        reg_wr(12, 16'h0002);
        sweep("");
        // configuration 4: A on k=0, B off
        reg_wr(12, 16'h0001);
        sweep("");
        finish_run();
    end
endmodule